// File: doc/BRIEF.md
# Overlapping Register Window Mapper

This block turns a thread's architectural register number into a physical address in a shared register file. Each family of threads splits its 31 architectural registers into four classes. Globals are written by the parent and only read by the children. Shareds are written once by a thread and read by its successor. Locals are private to the thread. Dependents are a read-only view of the predecessor's shareds. Architectural numbering puts the globals first, then the shareds, then the locals, then the dependents. Numbers past the last dependent are not mapped.

Each thread owns a window of NS+NL physical registers, with its shareds at the bottom and its locals above them. Globals and the first thread's dependents are redirected into the parent's local registers at the offsets the parent chose. A later thread's dependents are redirected onto the shareds of the thread just before it. The caller supplies the window base of the predecessor.

A request is registered once. The address, the class code and the flags appear on the next clock edge. The flags report an unmapped register, an illegal class split, and a write to a read-only class.

Top module: `rwin_mapper`

## Requirements
- R1: Global k (architectural k, for k < NG) maps to parent_loc_base + glb_ofs + k, with class code 0.
- R2: Shared k (architectural NG+k, for k < NS) maps to win_base + k, with class code 1.
- R3: Local k (architectural NG+NS+k, for k < NL) maps to win_base + NS + k, with class code 2.
- R4: For the first thread (first_thread=1), dependent k (architectural NG+NS+NL+k, for k < NS) maps to parent_loc_base + shr_ofs + k, with class code 3.
- R5: For any later thread, dependent k maps to pred_base + k, with class code 3.
- R6: An architectural number of NG+2*NS+NL or more is reported as unmapped=1 with class code 4. In that case the address is 0 and access_fault is 0.
- R7: When NG+NL+2*NS exceeds 31, size_err=1 and every request is treated as unmapped.
- R8: access_fault is 1 only for a write (is_write=1) to class 0 or class 3. Reads, and writes to class 1 or 2, give 0. The address is reported in every case.
- R9: The results appear one cycle after a request is accepted. A cycle with req_valid=0 gives rsp_valid=0, address 0, class code 4 and all flags 0.
- R10: While rst is high, the outputs hold the idle values of R9, whatever is driven at the inputs.
- R11: All address sums wrap modulo 2^PHYS_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| arch_idx | input | 5 | Architectural register number |
| is_write | input | 1 | Request is a write |
| first_thread | input | 1 | Thread is the first of its family |
| n_glb | input | 5 | Number of globals (NG) |
| n_shr | input | 5 | Number of shareds, also of dependents (NS) |
| n_loc | input | 5 | Number of locals (NL) |
| glb_ofs | input | 5 | Offset of the globals in the parent's locals (BG) |
| shr_ofs | input | 5 | Offset of the shareds in the parent's locals (BS) |
| win_base | input | PHYS_W | Physical base of this thread's window |
| pred_base | input | PHYS_W | Physical base of the predecessor's window |
| parent_loc_base | input | PHYS_W | Physical address of the parent's local 0 |
| rsp_valid | output | 1 | Result valid |
| phys_addr | output | PHYS_W | Physical register address |
| reg_class | output | 3 | 0 global, 1 shared, 2 local, 3 dependent, 4 none |
| unmapped | output | 1 | Architectural number outside the mapped classes |
| access_fault | output | 1 | Write to a global or a dependent |
| size_err | output | 1 | Class sizes exceed the architectural budget |

## Verification
The block holds only one register stage. A wrong class boundary or a wrong base selection therefore shows up on the very next cycle, as a wrong class code or a wrong address for the registers on either side of that boundary. The exhaustive sweep covers every architectural number for every small class split, for both first and later threads, and for reads and writes. Any misplaced boundary, a swapped base or a missing window offset reaches a compared result within one cycle of the request. The boundary splits exercise the point where the class budget is exactly full and the point where it is one register over.

// File: rtl/rwin_pkg.sv
package rwin_pkg;

    localparam int ARCH_W = 5;
    localparam int SUM_W  = ARCH_W + 3;

    typedef enum logic [2:0] {
        CLS_GLB  = 3'd0,
        CLS_SHR  = 3'd1,
        CLS_LOC  = 3'd2,
        CLS_DEP  = 3'd3,
        CLS_NONE = 3'd4
    } reg_cls_e;

    typedef struct packed {
        reg_cls_e            cls;
        logic [ARCH_W-1:0]   slot;
    } cls_hit_t;

    typedef struct packed {
        logic [ARCH_W-1:0] n_glb;
        logic [ARCH_W-1:0] n_shr;
        logic [ARCH_W-1:0] n_loc;
    } win_sizes_t;

    function automatic logic [SUM_W-1:0] widen(input logic [ARCH_W-1:0] v);
        return SUM_W'(v);
    endfunction

    function automatic logic is_readonly_cls(input reg_cls_e c);
        return (c == CLS_GLB) || (c == CLS_DEP);
    endfunction

endpackage

// File: rtl/rwin_classify.sv
module rwin_classify
    import rwin_pkg::*;
#(
    parameter int ARCH_LIMIT = 31
) (
    input  logic [ARCH_W-1:0] arch_idx,
    input  win_sizes_t        sz,
    output cls_hit_t          hit,
    output logic              size_err
);
    localparam logic [SUM_W-1:0] LIMIT = SUM_W'(ARCH_LIMIT);

    logic [SUM_W-1:0] g_end, s_end, l_end, d_end, idx;

    always_comb begin
        g_end    = widen(sz.n_glb);
        s_end    = g_end + widen(sz.n_shr);
        l_end    = s_end + widen(sz.n_loc);
        d_end    = l_end + widen(sz.n_shr);
        idx      = widen(arch_idx);
        size_err = (d_end > LIMIT);
        hit.cls  = CLS_NONE;
        hit.slot = '0;
        if (size_err || idx >= LIMIT) begin
            hit.cls = CLS_NONE;
        end else if (idx < g_end) begin
            hit.cls  = CLS_GLB;
            hit.slot = arch_idx;
        end else if (idx < s_end) begin
            hit.cls  = CLS_SHR;
            hit.slot = ARCH_W'(idx - g_end);
        end else if (idx < l_end) begin
            hit.cls  = CLS_LOC;
            hit.slot = ARCH_W'(idx - s_end);
        end else if (idx < d_end) begin
            hit.cls  = CLS_DEP;
            hit.slot = ARCH_W'(idx - l_end);
        end
    end

endmodule

// File: rtl/rwin_addr_gen.sv
module rwin_addr_gen
    import rwin_pkg::*;
#(
    parameter int PHYS_W = 10
) (
    input  cls_hit_t          hit,
    input  logic              first_thread,
    input  logic [ARCH_W-1:0] n_shr,
    input  logic [ARCH_W-1:0] glb_ofs,
    input  logic [ARCH_W-1:0] shr_ofs,
    input  logic [PHYS_W-1:0] win_base,
    input  logic [PHYS_W-1:0] pred_base,
    input  logic [PHYS_W-1:0] parent_loc_base,
    output logic [PHYS_W-1:0] phys
);
    logic [PHYS_W-1:0] slot_w;

    always_comb begin
        slot_w = PHYS_W'(hit.slot);
        unique case (hit.cls)
            CLS_GLB: phys = parent_loc_base + PHYS_W'(glb_ofs) + slot_w;
            CLS_SHR: phys = win_base + slot_w;
            CLS_LOC: phys = win_base + PHYS_W'(n_shr) + slot_w;
            CLS_DEP: phys = first_thread
                          ? parent_loc_base + PHYS_W'(shr_ofs) + slot_w
                          : pred_base + slot_w;
            default: phys = '0;
        endcase
    end

endmodule

// File: rtl/rwin_guard.sv
module rwin_guard
    import rwin_pkg::*;
(
    input  reg_cls_e cls,
    input  logic     is_write,
    output logic     fault,
    output logic     unmapped
);
    always_comb begin
        fault    = is_write && is_readonly_cls(cls);
        unmapped = (cls == CLS_NONE);
    end

endmodule

// File: rtl/rwin_mapper.sv
module rwin_mapper
    import rwin_pkg::*;
#(
    parameter int PHYS_W     = 10,
    parameter int ARCH_LIMIT = 31
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [4:0]        arch_idx,
    input  logic              is_write,
    input  logic              first_thread,
    input  logic [4:0]        n_glb,
    input  logic [4:0]        n_shr,
    input  logic [4:0]        n_loc,
    input  logic [4:0]        glb_ofs,
    input  logic [4:0]        shr_ofs,
    input  logic [PHYS_W-1:0] win_base,
    input  logic [PHYS_W-1:0] pred_base,
    input  logic [PHYS_W-1:0] parent_loc_base,
    output logic              rsp_valid,
    output logic [PHYS_W-1:0] phys_addr,
    output logic [2:0]        reg_class,
    output logic              unmapped,
    output logic              access_fault,
    output logic              size_err
);
    win_sizes_t        sizes;
    cls_hit_t          hit;
    logic              serr_d, fault_d, unm_d;
    logic [PHYS_W-1:0] addr_d;

    assign sizes = '{n_glb: n_glb, n_shr: n_shr, n_loc: n_loc};

    rwin_classify #(.ARCH_LIMIT(ARCH_LIMIT)) u_cls (
        .arch_idx (arch_idx),
        .sz       (sizes),
        .hit      (hit),
        .size_err (serr_d)
    );

    rwin_addr_gen #(.PHYS_W(PHYS_W)) u_addr (
        .hit             (hit),
        .first_thread    (first_thread),
        .n_shr           (n_shr),
        .glb_ofs         (glb_ofs),
        .shr_ofs         (shr_ofs),
        .win_base        (win_base),
        .pred_base       (pred_base),
        .parent_loc_base (parent_loc_base),
        .phys            (addr_d)
    );

    rwin_guard u_guard (
        .cls      (hit.cls),
        .is_write (is_write),
        .fault    (fault_d),
        .unmapped (unm_d)
    );

    always_ff @(posedge clk) begin
        if (rst || !req_valid) begin
            rsp_valid    <= 1'b0;
            phys_addr    <= '0;
            reg_class    <= CLS_NONE;
            unmapped     <= 1'b0;
            access_fault <= 1'b0;
            size_err     <= 1'b0;
        end else begin
            rsp_valid    <= 1'b1;
            phys_addr    <= addr_d;
            reg_class    <= hit.cls;
            unmapped     <= unm_d;
            access_fault <= fault_d;
            size_err     <= serr_d;
        end
    end

    // R8
    fault_class_chk: assert property (@(posedge clk) disable iff (rst)
        access_fault |-> (reg_class == CLS_GLB || reg_class == CLS_DEP));

    // R8
    fault_write_chk: assert property (@(posedge clk) disable iff (rst)
        access_fault |-> $past(is_write));

    // R6
    unmapped_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        unmapped |-> (phys_addr == '0 && !access_fault && reg_class == CLS_NONE));

    // R7
    size_err_unmapped_chk: assert property (@(posedge clk) disable iff (rst)
        size_err |-> unmapped);

    // R2
    shared_window_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && reg_class == CLS_SHR) |->
            ((phys_addr - $past(win_base)) < PHYS_W'($past(n_shr))));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !rsp_valid |-> (phys_addr == '0 && !access_fault && !unmapped && !size_err));

endmodule

// File: tb/rwin_mapper_test.sv
`timescale 1ns/100ps
module rwin_mapper_test;
    localparam int PW = 10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [4:0]    arch_idx = '0;
    logic          is_write = 1'b0;
    logic          first_thread = 1'b0;
    logic [4:0]    n_glb = '0, n_shr = '0, n_loc = '0, glb_ofs = '0, shr_ofs = '0;
    logic [PW-1:0] win_base = '0, pred_base = '0, parent_loc_base = '0;
    logic          rsp_valid, unmapped, access_fault, size_err;
    logic [PW-1:0] phys_addr;
    logic [2:0]    reg_class;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    rwin_mapper #(.PHYS_W(PW)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .arch_idx(arch_idx),
        .is_write(is_write), .first_thread(first_thread),
        .n_glb(n_glb), .n_shr(n_shr), .n_loc(n_loc),
        .glb_ofs(glb_ofs), .shr_ofs(shr_ofs),
        .win_base(win_base), .pred_base(pred_base), .parent_loc_base(parent_loc_base),
        .rsp_valid(rsp_valid), .phys_addr(phys_addr), .reg_class(reg_class),
        .unmapped(unmapped), .access_fault(access_fault), .size_err(size_err)
    );

    task automatic compare(input string tag, input logic v, input logic [PW-1:0] a,
                           input logic [2:0] c, input logic u, input logic f, input logic s);
        n_checks++;
        if (rsp_valid !== v || phys_addr !== a || reg_class !== c ||
            unmapped !== u || access_fault !== f || size_err !== s) begin
            n_fails++;
            $display("FAIL %s: got v=%0b a=%0d c=%0d u=%0b f=%0b s=%0b exp v=%0b a=%0d c=%0d u=%0b f=%0b s=%0b",
                     tag, rsp_valid, phys_addr, reg_class, unmapped, access_fault, size_err,
                     v, a, c, u, f, s);
        end
    endtask

    // Drive one request at a negedge, compare at the following negedge.
    task automatic run_one(input int ng, input int ns, input int nl, input int ft,
                           input int wr, input int a, input int wb, input int pb, input int plb,
                           input int go, input int so);
        int ge, se, le, de;
        logic [PW-1:0] ea;
        logic [2:0]    ec;
        logic          eu, ef, es;
        string         tag;
        req_valid = 1'b1;
        arch_idx = 5'(a); is_write = wr[0]; first_thread = ft[0];
        n_glb = 5'(ng); n_shr = 5'(ns); n_loc = 5'(nl);
        glb_ofs = 5'(go); shr_ofs = 5'(so);
        win_base = PW'(wb); pred_base = PW'(pb); parent_loc_base = PW'(plb);
        ge = ng; se = ge + ns; le = se + nl; de = le + ns;
        ea = '0; ec = 3'd4; eu = 1'b1; es = 1'b0;
        if (de > 31) begin
            es = 1'b1; tag = "R7";
        end else if (a < ge) begin
            ea = PW'(plb + go + a); ec = 3'd0; eu = 1'b0; tag = "R1";
        end else if (a < se) begin
            ea = PW'(wb + (a - ge)); ec = 3'd1; eu = 1'b0; tag = "R2";
        end else if (a < le) begin
            ea = PW'(wb + ns + (a - se)); ec = 3'd2; eu = 1'b0; tag = "R3";
        end else if (a < de) begin
            ec = 3'd3; eu = 1'b0;
            if (ft != 0) begin ea = PW'(plb + so + (a - le)); tag = "R4"; end
            else         begin ea = PW'(pb + (a - le));       tag = "R5"; end
        end else begin
            tag = "R6";
        end
        ef = (wr != 0) && (ec == 3'd0 || ec == 3'd3);
        if (wr != 0) tag = {tag, "/R8"};
        if (wb + 40 > 1023) tag = {tag, "/R11"};
        @(negedge clk);
        compare(tag, 1'b1, ea, ec, eu, ef, es);
    endtask

    initial begin
        // R10: reset holds idle outputs even with a request present
        req_valid = 1'b1; n_glb = 5'd2; arch_idx = 5'd0; is_write = 1'b1;
        @(negedge clk); @(negedge clk);
        compare("R10 reset", 1'b0, '0, 3'd4, 1'b0, 1'b0, 1'b0);
        rst = 1'b0; req_valid = 1'b0;
        @(negedge clk);
        compare("R9 idle", 1'b0, '0, 3'd4, 1'b0, 1'b0, 1'b0);

        // Exhaustive sweep over small class splits.
        for (int ng = 0; ng < 4; ng++)
            for (int ns = 0; ns < 4; ns++)
                for (int nl = 0; nl < 4; nl++)
                    for (int ft = 0; ft < 2; ft++)
                        for (int wr = 0; wr < 2; wr++)
                            for (int a = 0; a < 32; a++)
                                run_one(ng, ns, nl, ft, wr, a,
                                        1000 + ng*13 + ns*7 + nl*3,
                                        (1000 + ng*13 + ns*7 + nl*3) - (ns + nl),
                                        40*ng + 5, ns + 1, ng + 2);

        // R9: gap after traffic
        req_valid = 1'b0;
        @(negedge clk);
        compare("R9 gap", 1'b0, '0, 3'd4, 1'b0, 1'b0, 1'b0);

        // Boundary splits: budget exactly full and one over (R7).
        for (int ft = 0; ft < 2; ft++)
            for (int a = 0; a < 32; a++) begin
                run_one(10, 6, 9, ft, 1, a, 300, 280, 700, 3, 17);
                run_one(10, 6, 10, ft, 0, a, 300, 280, 700, 3, 17);
                run_one(0, 15, 1, ft, 0, a, 1015, 999, 1020, 0, 9);
                run_one(31, 0, 0, ft, 1, a, 12, 0, 1010, 31, 0);
                run_one(0, 0, 31, ft, 1, a, 1010, 0, 0, 0, 0);
                run_one(31, 31, 31, ft, 0, a, 1, 2, 3, 4, 5);
            end

        req_valid = 1'b0;
        @(negedge clk);
        compare("R9 final idle", 1'b0, '0, 3'd4, 1'b0, 1'b0, 1'b0);

        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            finished = 1;
            n_checks++; n_fails++;
            $display("FAIL watchdog: got running exp done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule